// File: doc/BRIEF.md
# Core Idle-State Sequencer

A per-core controller that moves a processor core from its running state into one of three idle depths and back. Each hardware thread of the core raises an idle request carrying a depth code (halt or monitored wait). When every thread is requesting, the block takes the shallowest of the requested depths as the core depth. It then walks that depth's fixed entry sequence, one request/acknowledge handshake per step, against external agents: private cache flush, clock stop, architectural state save and voltage removal.

A wake event (interrupt or similar) brings the core back to running. Exit runs the finished steps in reverse order: power restore, state restore, clock restart. A wake that arrives in the middle of entry lets the current step finish and then unwinds. The block reports the current idle depth on a 2-bit status output. It also reports whether coherence snoops are still being served.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the core is running: `running_o`=1, `cstate_o`=0, `snoop_en_o`=1 and `step_req_o`=0.
- R2: The core leaves running only on a clock edge where every thread's bit in `thr_req_i` is 1 and `wake_i` is 0. With any thread not requesting, or with `wake_i` high, it stays running.
- R3: Each thread's 2-bit depth code is 0=C1, 1=C2, 2=C3, 3=C6, with thread t in bits [2t+1:2t]. C2 is handled as C1. The core depth is the shallowest of the threads' depths.
- R4: C1 is entered on the edge after the request. It shows `cstate_o`=1, `snoop_en_o`=1 and no step requests. A wake returns `running_o`=1 on the next edge.
- R5: C3 entry requests flush (`step_req_o` bit 0), then clock stop (bit 1). After that it rests with `cstate_o`=2 and `snoop_en_o`=0.
- R6: C6 entry performs the C3 steps, then state save (bit 2), then power off (bit 3). It then rests with `cstate_o`=3 and `snoop_en_o`=0.
- R7: At most one bit of `step_req_o` is high at a time. A raised step request stays unchanged until the same bit of `step_ack_i` is seen.
- R8: On wake, exit from C6 requests power on (bit 4), then state restore (bit 5), then clock on (bit 6). Exit from C3 requests clock on only. Running is reported after the last acknowledge.
- R9: A wake during entry lets the pending step complete, then unwinds. An abort after flush goes straight to running. An abort after clock stop or save restarts the clocks. An abort after power off runs the full C6 exit.
- R10: Once an idle depth is reached, it is held until a wake, whatever the thread request inputs do.
- R11: `snoop_en_o` is high exactly when `cstate_o` is 0 or 1. During flush `cstate_o` reads 1. During clock stop, save and power off it reads 2. During power on and restore it reads 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| thr_req_i | input | NTHR | Per-thread idle request |
| thr_code_i | input | 2*NTHR | Per-thread depth code |
| wake_i | input | 1 | Wake event |
| step_ack_i | input | 7 | Step acknowledges, bit per step |
| step_req_o | output | 7 | Step requests, bit per step |
| cstate_o | output | 2 | Current depth: 0=C0, 1=C1, 2=C3, 3=C6 |
| snoop_en_o | output | 1 | Coherence snoops served |
| running_o | output | 1 | Core executing |

## Verification
A wrong state register shows up at once, on the next edge, as a step request out of order or as two requests at once. It can also show as a `cstate_o` or `snoop_en_o` value that does not fit the depth just reached. A lost or stuck pending-wake flag shows up later: the wrong unwind path appears only at the step boundary after the wake. For that reason the bench stalls acknowledges so that the wake lands mid-step, and it compares the whole logged step order.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
  typedef enum logic [1:0] {LV_C0 = 2'd0, LV_C1 = 2'd1, LV_C3 = 2'd2, LV_C6 = 2'd3} lvl_e;

  typedef enum logic [3:0] {
    S_RUN, S_C1, S_FLUSH, S_CLKOFF, S_SAVE, S_PWROFF,
    S_C3, S_C6, S_PWRON, S_RESTORE, S_CLKON
  } st_e;

  localparam int unsigned NSTEP     = 7;
  localparam int unsigned STP_FLUSH = 0;
  localparam int unsigned STP_CLKOFF= 1;
  localparam int unsigned STP_SAVE  = 2;
  localparam int unsigned STP_PWROFF= 3;
  localparam int unsigned STP_PWRON = 4;
  localparam int unsigned STP_RESTR = 5;
  localparam int unsigned STP_CLKON = 6;

  function automatic lvl_e code_to_lvl(input logic [1:0] code);
    case (code)
      2'd2:    return LV_C3;
      2'd3:    return LV_C6;
      default: return LV_C1; // C1 and C2 share the halt depth
    endcase
  endfunction
endpackage

// File: rtl/cidle_depth_resolve.sv
module cidle_depth_resolve
  import cidle_pkg::*;
#(
  parameter int unsigned NTHR = 2
) (
  input  logic [NTHR-1:0]   req_i,
  input  logic [2*NTHR-1:0] code_i,
  output logic              all_idle_o,
  output lvl_e              lvl_o
);
  lvl_e thr_lvl [NTHR];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign thr_lvl[t] = code_to_lvl(code_i[2*t+1:2*t]);
  end

  assign all_idle_o = &req_i;

  always_comb begin
    lvl_o = LV_C6;
    for (int t = 0; t < NTHR; t++) begin
      if (thr_lvl[t] < lvl_o) lvl_o = thr_lvl[t];
    end
  end
endmodule

// File: rtl/cidle_step_fsm.sv
module cidle_step_fsm
  import cidle_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  lvl_e             lvl_i,
  input  logic             wake_i,
  input  logic [NSTEP-1:0] ack_i,
  output st_e              st_o
);
  st_e  st_q, st_d;
  lvl_e tgt_q, tgt_d;
  logic wpend_q, wpend_d;
  logic abort;

  assign abort = wpend_q | wake_i;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    unique case (st_q)
      S_RUN: if (go_i) begin
        tgt_d = lvl_i;
        st_d  = (lvl_i == LV_C1) ? S_C1 : S_FLUSH;
      end
      S_C1:      if (wake_i) st_d = S_RUN;
      S_FLUSH:   if (ack_i[STP_FLUSH])  st_d = abort ? S_RUN : S_CLKOFF;
      S_CLKOFF:  if (ack_i[STP_CLKOFF]) st_d = abort ? S_CLKON :
                                               (tgt_q == LV_C3) ? S_C3 : S_SAVE;
      S_SAVE:    if (ack_i[STP_SAVE])   st_d = abort ? S_CLKON : S_PWROFF;
      S_PWROFF:  if (ack_i[STP_PWROFF]) st_d = abort ? S_PWRON : S_C6;
      S_C3:      if (wake_i) st_d = S_CLKON;
      S_C6:      if (wake_i) st_d = S_PWRON;
      S_PWRON:   if (ack_i[STP_PWRON])  st_d = S_RESTORE;
      S_RESTORE: if (ack_i[STP_RESTR])  st_d = S_CLKON;
      S_CLKON:   if (ack_i[STP_CLKON])  st_d = S_RUN;
      default:   st_d = S_RUN;
    endcase
  end

  // wake remembered only while an entry step is still pending
  always_comb begin
    unique case (st_d)
      S_FLUSH, S_CLKOFF, S_SAVE, S_PWROFF:
        wpend_d = (st_d == st_q) ? abort : wake_i;
      default: wpend_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_RUN;
      tgt_q   <= LV_C1;
      wpend_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      wpend_q <= wpend_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/cidle_status_dec.sv
module cidle_status_dec
  import cidle_pkg::*;
(
  input  st_e              st_i,
  output logic [NSTEP-1:0] step_req_o,
  output logic [1:0]       cstate_o,
  output logic             snoop_en_o,
  output logic             running_o
);
  lvl_e lvl;

  always_comb begin
    step_req_o = '0;
    lvl        = LV_C0;
    unique case (st_i)
      S_RUN:     lvl = LV_C0;
      S_C1:      lvl = LV_C1;
      S_FLUSH:   begin lvl = LV_C1; step_req_o[STP_FLUSH]  = 1'b1; end
      S_CLKOFF:  begin lvl = LV_C3; step_req_o[STP_CLKOFF] = 1'b1; end
      S_SAVE:    begin lvl = LV_C3; step_req_o[STP_SAVE]   = 1'b1; end
      S_PWROFF:  begin lvl = LV_C3; step_req_o[STP_PWROFF] = 1'b1; end
      S_C3:      lvl = LV_C3;
      S_C6:      lvl = LV_C6;
      S_PWRON:   begin lvl = LV_C6; step_req_o[STP_PWRON]  = 1'b1; end
      S_RESTORE: begin lvl = LV_C6; step_req_o[STP_RESTR]  = 1'b1; end
      S_CLKON:   begin lvl = LV_C3; step_req_o[STP_CLKON]  = 1'b1; end
      default:   lvl = LV_C0;
    endcase
  end

  assign cstate_o   = lvl;
  assign snoop_en_o = (lvl == LV_C0) || (lvl == LV_C1);
  assign running_o  = (st_i == S_RUN);
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import cidle_pkg::*;
#(
  parameter int unsigned NTHR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NTHR-1:0]   thr_req_i,
  input  logic [2*NTHR-1:0] thr_code_i,
  input  logic              wake_i,
  input  logic [6:0]        step_ack_i,
  output logic [6:0]        step_req_o,
  output logic [1:0]        cstate_o,
  output logic              snoop_en_o,
  output logic              running_o
);
  logic all_idle;
  lvl_e lvl;
  st_e  st;

  cidle_depth_resolve #(.NTHR(NTHR)) i_resolve (
    .req_i      (thr_req_i),
    .code_i     (thr_code_i),
    .all_idle_o (all_idle),
    .lvl_o      (lvl)
  );

  cidle_step_fsm i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (all_idle & ~wake_i),
    .lvl_i  (lvl),
    .wake_i (wake_i),
    .ack_i  (step_ack_i),
    .st_o   (st)
  );

  cidle_status_dec i_dec (
    .st_i       (st),
    .step_req_o (step_req_o),
    .cstate_o   (cstate_o),
    .snoop_en_o (snoop_en_o),
    .running_o  (running_o)
  );
endmodule

// File: rtl/core_idle_seq_chk.sv
module core_idle_seq_chk #(
  parameter int unsigned NTHR = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NTHR-1:0] thr_req_i,
  input logic            wake_i,
  input logic [6:0]      step_ack_i,
  input logic [6:0]      step_req_o,
  input logic [1:0]      cstate_o,
  input logic            snoop_en_o,
  input logic            running_o
);
  p_one_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_req_o));

  p_req_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_req_o != 7'd0 && (step_req_o & step_ack_i) == 7'd0) |=> $stable(step_req_o));

  p_stay_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && (!(&thr_req_i) || wake_i)) |=> running_o);

  p_c1_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o == 2'd1 && step_req_o == 7'd0 && wake_i) |=> running_o);

  p_deep_no_snoop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o >= 2'd2) |-> !snoop_en_o);

  p_save_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_req_o[2]) |-> $past(step_req_o[1]));

  p_pwroff_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_req_o[3]) |-> $past(step_req_o[2]));

  p_restore_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_req_o[5]) |-> $past(step_req_o[4]));

  p_held_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cstate_o >= 2'd2 && step_req_o == 7'd0 && !wake_i) |=> $stable(cstate_o));
endmodule

bind core_idle_seq core_idle_seq_chk #(.NTHR(NTHR)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .thr_req_i  (thr_req_i),
  .wake_i     (wake_i),
  .step_ack_i (step_ack_i),
  .step_req_o (step_req_o),
  .cstate_o   (cstate_o),
  .snoop_en_o (snoop_en_o),
  .running_o  (running_o)
);

// File: tb/test_core_idle_seq.sv
module test_core_idle_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] thr_req = '0;
  logic [3:0] thr_code = '0;
  logic       wake = 1'b0;
  logic [6:0] step_ack = '0;
  logic [6:0] step_req;
  logic [1:0] cstate;
  logic       snoop_en, running;

  int checks = 0;
  int fails  = 0;

  logic [6:0]  ack_mask = 7'h7f;
  logic        clr_log  = 1'b0;
  logic [31:0] seq_log  = '0;

  always #4 clk = ~clk;

  core_idle_seq i_core_idle_seq (
    .clk_i(clk), .rst_ni(rst_n), .thr_req_i(thr_req), .thr_code_i(thr_code),
    .wake_i(wake), .step_ack_i(step_ack), .step_req_o(step_req),
    .cstate_o(cstate), .snoop_en_o(snoop_en), .running_o(running));

  // step responder: acks enabled steps, logs each as (bit index + 1)
  always @(negedge clk) begin
    if (clr_log) seq_log <= '0;
    else if ((step_req & ack_mask) != 7'd0) begin
      for (int b = 0; b < 7; b++)
        if (step_req[b] & ack_mask[b]) seq_log <= {seq_log[27:0], 4'(b + 1)};
    end
    step_ack <= step_req & ack_mask;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    clr_log = 1'b1; tick(1); clr_log = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(1); wake = 1'b0;
  endtask

  // {req[1:0], code_t0, code_t1, exp_level, exp_step_log}
  localparam int NV = 9;
  localparam logic [39:0] VEC [NV] = '{
    {2'b11, 2'd0, 2'd0, 2'd1, 32'h0},
    {2'b11, 2'd1, 2'd1, 2'd1, 32'h0},
    {2'b11, 2'd3, 2'd3, 2'd3, 32'h1234567},
    {2'b11, 2'd3, 2'd2, 2'd2, 32'h127},
    {2'b11, 2'd2, 2'd3, 2'd2, 32'h127},
    {2'b11, 2'd3, 2'd1, 2'd1, 32'h0},
    {2'b01, 2'd3, 2'd3, 2'd0, 32'h0},
    {2'b10, 2'd2, 2'd2, 2'd0, 32'h0},
    {2'b11, 2'd2, 2'd2, 2'd2, 32'h127}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 running", running, 1);
    chk("R1 cstate", cstate, 0);
    chk("R1 snoop", snoop_en, 1);
    chk("R1 step_req", step_req, 0);

    for (int v = 0; v < NV; v++) begin
      clear_log();
      thr_req  = VEC[v][39:38];
      thr_code = {VEC[v][35:34], VEC[v][37:36]};
      tick(12);
      chk("R3 depth", cstate, VEC[v][33:32]);
      chk("R11 snoop", snoop_en, (VEC[v][33:32] <= 2'd1) ? 1 : 0);
      thr_req = 2'b00;
      pulse_wake();
      tick(12);
      chk("R8 back running", running, 1);
      chk("R5 R6 R8 step order", seq_log, VEC[v][31:0]);
    end

    // R2: wake in the same edge blocks entry
    thr_code = 4'h0; thr_req = 2'b11; wake = 1'b1;
    tick(1);
    chk("R2 wake blocks entry", running, 1);
    wake = 1'b0;
    tick(1);
    chk("R4 C1 next edge", cstate, 1);
    chk("R4 C1 no steps", step_req, 0);
    thr_req = 2'b00;
    pulse_wake();
    chk("R4 wake one edge", running, 1);

    // R10: held in C3 with requests dropped
    clear_log();
    thr_code = 4'hA; thr_req = 2'b11;
    tick(8);
    thr_req = 2'b00;
    tick(6);
    chk("R10 C3 held", cstate, 2);
    chk("R10 no steps", step_req, 0);
    pulse_wake(); tick(6);
    chk("R10 exit", running, 1);

    // R7/R9: stall at clock stop, wake mid-step
    clear_log();
    ack_mask = 7'b1111101;
    thr_code = 4'hF; thr_req = 2'b11;
    tick(6);
    chk("R7 clkstop held", step_req, 7'b0000010);
    chk("R11 clkstop cstate", cstate, 2);
    chk("R11 clkstop snoop", snoop_en, 0);
    thr_req = 2'b00;
    pulse_wake(); tick(3);
    chk("R9 waits boundary", step_req, 7'b0000010);
    ack_mask = 7'h7f;
    tick(8);
    chk("R9 abort clkstop run", running, 1);
    chk("R9 abort clkstop order", seq_log, 32'h127);

    // R9: stall at save
    clear_log();
    ack_mask = 7'b1111011;
    thr_req = 2'b11;
    tick(6);
    chk("R7 save held", step_req, 7'b0000100);
    thr_req = 2'b00;
    pulse_wake();
    ack_mask = 7'h7f;
    tick(8);
    chk("R9 abort save order", seq_log, 32'h1237);

    // R9: stall at power off
    clear_log();
    ack_mask = 7'b1110111;
    thr_req = 2'b11;
    tick(8);
    chk("R7 pwroff held", step_req, 7'b0001000);
    thr_req = 2'b00;
    pulse_wake();
    ack_mask = 7'h7f;
    tick(10);
    chk("R9 abort pwroff order", seq_log, 32'h1234567);
    chk("R9 abort pwroff run", running, 1);

    // R9: stall at flush, abort goes straight to running
    clear_log();
    ack_mask = 7'b1111110;
    thr_req = 2'b11;
    tick(4);
    chk("R11 flush cstate", cstate, 1);
    chk("R11 flush snoop", snoop_en, 1);
    thr_req = 2'b00;
    pulse_wake();
    ack_mask = 7'h7f;
    tick(6);
    chk("R9 abort flush order", seq_log, 32'h1);
    chk("R9 abort flush run", running, 1);

    // R8: C6 exit, check power-on stage status
    clear_log();
    ack_mask = 7'b1101111;
    thr_req = 2'b11;
    tick(10);
    thr_req = 2'b00;
    pulse_wake(); tick(2);
    chk("R8 power on first", step_req, 7'b0010000);
    chk("R11 power on cstate", cstate, 3);
    ack_mask = 7'h7f;
    tick(6);
    chk("R8 C6 exit order", seq_log, 32'h1234567);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule